// File: doc/BRIEF.md
# Soft-Start and Fault Hiccup Sequencer

This block supervises the startup and fault recovery of a digital PWM pulse generator. A saturating counter stands in for a soft-start capacitor. It climbs by a programmable charge step after power is good and serves as a ceiling on the control level that feeds the modulator. While the ceiling is low, the modulator therefore sees a low control level. As the counter rises, the control level follows it until the requested demand is below the ceiling and regulation takes over.

An overcurrent input drops the output enable in the same cycle and latches a fault. The counter then empties by a separate, normally much larger, discharge step. Pulses resume only after the counter is empty and the overcurrent input has gone away. If the fault arrives while the counter is still climbing, the enable drops at once, but the counter keeps charging to full scale before it empties. A continuous fault therefore repeats with a bounded hiccup period and never restarts at once. Two supply-health inputs act as an undervoltage lockout: when either one is low, the sequencer returns to its idle state with the counter cleared.

Top module: `hiccup_seq`

## Requirements
- R1: After reset the state code is 0 (idle lockout), the ceiling is 0, and outEnable, faultFlag and clampedLevel are all 0.
- R2: At a clock edge where supplyOk or refOk is low, the next state is 0 with the ceiling at 0 and faultFlag low. outEnable is low in any cycle where either bit is low.
- R3: In state 0 with both health bits high, the next state is 1 (ramping) with the ceiling still 0. Each cycle in state 1 adds chargeStep to the ceiling, saturating at 2^CNT_W-1. The edge that reaches that maximum enters state 2 (running), and in state 2 the ceiling stays at the maximum.
- R4: clampedLevel equals the smaller of demand and the ceiling while outEnable is high, and 0 otherwise.
- R5: outEnable is high only in states 1 and 2, with ovrCurrent low and both health bits high. Raising ovrCurrent drops it in the same cycle, before any clock edge.
- R6: An edge in state 2 with ovrCurrent high enters state 4 (discharging), with the ceiling still at maximum. faultFlag is high exactly in states 3 and 4.
- R7: An edge in state 1 with ovrCurrent high enters state 3 (fault while charging), and the ceiling keeps rising by chargeStep. The edge at which the ceiling reaches its maximum, from state 3 or state 1 under overcurrent, enters state 4.
- R8: Each cycle in state 4 subtracts dischargeStep from the ceiling, stopping at 0. The block leaves state 4 for state 1 only at an edge where the ceiling is already 0 and ovrCurrent is low. Otherwise it stays in state 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ovrCurrent | input | 1 | Overcurrent trip, active high |
| supplyOk | input | 1 | Main supply above its lockout threshold |
| refOk | input | 1 | Reference supply within range |
| chargeStep | input | CNT_W | Ceiling increment per cycle while charging |
| dischargeStep | input | CNT_W | Ceiling decrement per cycle while discharging |
| demand | input | CNT_W | Control level requested by the regulation loop |
| outEnable | output | 1 | Pulse generator may drive its outputs |
| faultFlag | output | 1 | Fault latch is set |
| ssLevel | output | CNT_W | Current soft-start ceiling |
| clampedLevel | output | CNT_W | Demand limited by the ceiling, 0 when disabled |
| seqState | output | 3 | Sequencer state code (0 to 4) |

## Verification
The main stimulus is a clean startup, followed by an overcurrent pulse once the ceiling is full and another during the ramp. Comparing these two cases shows whether discharge starts at once or waits for full charge. An overcurrent held after the ceiling has reached zero shows that the fault latch needs both conditions before it releases. Dropping each health bit alone shows that either bit forces lockout. Full-scale step sizes exercise saturation at both ends. The ovrCurrent input is also checked between clock edges to confirm that the enable falls before any edge occurs.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic [2:0] {
    SEQ_LOCKOUT = 3'd0,
    SEQ_RAMP    = 3'd1,
    SEQ_RUN     = 3'd2,
    SEQ_FCHG    = 3'd3,
    SEQ_FDIS    = 3'd4
  } seqState_e;

  // strobes from control to the ceiling datapath
  typedef struct packed {
    logic clr;
    logic chg;
    logic dis;
  } rampCmd_t;

endpackage

// File: rtl/hiccup_ramp_dp.sv
module hiccup_ramp_dp #(
  parameter int CNT_W = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  hiccup_pkg::rampCmd_t      cmd,
  input  logic [CNT_W-1:0]          chargeStep,
  input  logic [CNT_W-1:0]          dischargeStep,
  output logic [CNT_W-1:0]          level,
  output logic                      willFill,
  output logic                      isEmpty
);
  localparam logic [CNT_W-1:0] LVL_MAX = {CNT_W{1'b1}};

  logic [CNT_W:0]   sumWide;
  logic [CNT_W-1:0] chgSat;
  logic [CNT_W-1:0] disSat;

  always_comb begin
    sumWide  = {1'b0, level} + {1'b0, chargeStep};
    chgSat   = sumWide[CNT_W] ? LVL_MAX : sumWide[CNT_W-1:0];
    disSat   = (level < dischargeStep) ? '0 : level - dischargeStep;
    willFill = (chgSat == LVL_MAX);
    isEmpty  = (level == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        level <= '0;
    else if (cmd.clr) level <= '0;
    else if (cmd.chg) level <= chgSat;
    else if (cmd.dis) level <= disSat;
  end
endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ovrCurrent,
  input  logic                   uvOk,
  input  logic                   willFill,
  input  logic                   isEmpty,
  output hiccup_pkg::rampCmd_t   cmd,
  output hiccup_pkg::seqState_e  state,
  output logic                   outEnable,
  output logic                   faultFlag
);
  import hiccup_pkg::*;

  seqState_e nxt;

  always_comb begin
    nxt = state;
    cmd = '0;
    if (!uvOk) begin
      nxt     = SEQ_LOCKOUT;
      cmd.clr = 1'b1;
    end else begin
      unique case (state)
        SEQ_LOCKOUT: begin
          nxt     = SEQ_RAMP;
          cmd.clr = 1'b1;
        end
        SEQ_RAMP: begin
          cmd.chg = 1'b1;
          if (willFill)        nxt = ovrCurrent ? SEQ_FDIS : SEQ_RUN;
          else if (ovrCurrent) nxt = SEQ_FCHG;
        end
        SEQ_RUN: begin
          if (ovrCurrent) nxt = SEQ_FDIS;
        end
        SEQ_FCHG: begin
          cmd.chg = 1'b1;
          if (willFill) nxt = SEQ_FDIS;
        end
        SEQ_FDIS: begin
          cmd.dis = 1'b1;
          if (isEmpty && !ovrCurrent) nxt = SEQ_RAMP;
        end
        default: begin
          nxt     = SEQ_LOCKOUT;
          cmd.clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_LOCKOUT;
    else       state <= nxt;
  end

  always_comb begin
    outEnable = (state == SEQ_RAMP || state == SEQ_RUN) && !ovrCurrent && uvOk;
    faultFlag = (state == SEQ_FCHG || state == SEQ_FDIS);
  end
endmodule

// File: rtl/hiccup_clamp.sv
module hiccup_clamp #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] demand,
  input  logic [CNT_W-1:0] ceiling,
  input  logic             enable,
  output logic [CNT_W-1:0] limited
);
  always_comb begin
    if (!enable)              limited = '0;
    else if (demand < ceiling) limited = demand;
    else                      limited = ceiling;
  end
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ovrCurrent,
  input  logic             supplyOk,
  input  logic             refOk,
  input  logic [CNT_W-1:0] chargeStep,
  input  logic [CNT_W-1:0] dischargeStep,
  input  logic [CNT_W-1:0] demand,
  output logic             outEnable,
  output logic             faultFlag,
  output logic [CNT_W-1:0] ssLevel,
  output logic [CNT_W-1:0] clampedLevel,
  output logic [2:0]       seqState
);
  import hiccup_pkg::*;

  rampCmd_t  rampCmd;
  seqState_e stateQ;
  logic      willFill;
  logic      isEmpty;
  logic      uvOk;

  assign uvOk     = supplyOk & refOk;
  assign seqState = stateQ;

  hiccup_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .ovrCurrent (ovrCurrent),
    .uvOk       (uvOk),
    .willFill   (willFill),
    .isEmpty    (isEmpty),
    .cmd        (rampCmd),
    .state      (stateQ),
    .outEnable  (outEnable),
    .faultFlag  (faultFlag)
  );

  hiccup_ramp_dp #(.CNT_W(CNT_W)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .cmd           (rampCmd),
    .chargeStep    (chargeStep),
    .dischargeStep (dischargeStep),
    .level         (ssLevel),
    .willFill      (willFill),
    .isEmpty       (isEmpty)
  );

  hiccup_clamp #(.CNT_W(CNT_W)) clamp_i (
    .demand  (demand),
    .ceiling (ssLevel),
    .enable  (outEnable),
    .limited (clampedLevel)
  );
endmodule

// File: rtl/hiccup_seq_chk.sv
module hiccup_seq_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             ovrCurrent,
  input logic             supplyOk,
  input logic             refOk,
  input logic [CNT_W-1:0] demand,
  input logic             outEnable,
  input logic             faultFlag,
  input logic [CNT_W-1:0] ssLevel,
  input logic [CNT_W-1:0] clampedLevel,
  input logic [2:0]       seqState
);
  import hiccup_pkg::*;
  localparam logic [CNT_W-1:0] LVL_MAX = {CNT_W{1'b1}};

  assert_lockout_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(supplyOk && refOk) |=> (seqState == SEQ_LOCKOUT && ssLevel == '0 && !faultFlag));

  assert_run_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_RUN) |-> (ssLevel == LVL_MAX));

  assert_clamp_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clampedLevel <= ssLevel) && (clampedLevel <= demand) && (outEnable || clampedLevel == '0));

  assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    outEnable |-> (!ovrCurrent && !faultFlag && supplyOk && refOk));

  assert_run_fault_R6: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_RUN && ovrCurrent && supplyOk && refOk)
      |=> (seqState == SEQ_FDIS && faultFlag && ssLevel == LVL_MAX));

  assert_fault_charge_R7: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_FCHG && supplyOk && refOk)
      |=> ((seqState == SEQ_FCHG || seqState == SEQ_FDIS) && ssLevel >= $past(ssLevel)));

  assert_discharge_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == SEQ_FDIS && supplyOk && refOk && !(ssLevel == '0 && !ovrCurrent))
      |=> (seqState == SEQ_FDIS && ssLevel <= $past(ssLevel)));
endmodule

bind hiccup_seq hiccup_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .ovrCurrent   (ovrCurrent),
  .supplyOk     (supplyOk),
  .refOk        (refOk),
  .demand       (demand),
  .outEnable    (outEnable),
  .faultFlag    (faultFlag),
  .ssLevel      (ssLevel),
  .clampedLevel (clampedLevel),
  .seqState     (seqState)
);

// File: tb/hiccup_seq_tb_top.sv
`timescale 1ns/1ps
module hiccup_seq_tb_top;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         ovrCurrent = 1'b0;
  logic         supplyOk = 1'b0;
  logic         refOk = 1'b0;
  logic [W-1:0] chargeStep = 12'd512;
  logic [W-1:0] dischargeStep = 12'd2048;
  logic [W-1:0] demand = 12'd1000;
  logic         outEnable, faultFlag;
  logic [W-1:0] ssLevel, clampedLevel;
  logic [2:0]   seqState;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  hiccup_seq #(.CNT_W(W)) dut_i (.*);

  typedef struct packed {
    logic        ovr;
    logic        sup;
    logic        rf;
    logic [2:0]  st;
    logic [11:0] lvl;
    logic        en;
    logic        flt;
    logic [11:0] clamp;
  } vec_t;

  // charge 512, discharge 2048, demand 1000; each row: inputs held across one edge
  localparam vec_t VECS [0:27] = '{
    '{1'b0,1'b1,1'b1,3'd1,12'd0,   1'b1,1'b0,12'd0},    // R3 leave lockout
    '{1'b0,1'b1,1'b1,3'd1,12'd512, 1'b1,1'b0,12'd512},  // R3 R4
    '{1'b0,1'b1,1'b1,3'd1,12'd1024,1'b1,1'b0,12'd1000}, // R4 demand below ceiling
    '{1'b0,1'b1,1'b1,3'd1,12'd1536,1'b1,1'b0,12'd1000},
    '{1'b0,1'b1,1'b1,3'd1,12'd2048,1'b1,1'b0,12'd1000},
    '{1'b0,1'b1,1'b1,3'd1,12'd2560,1'b1,1'b0,12'd1000},
    '{1'b0,1'b1,1'b1,3'd1,12'd3072,1'b1,1'b0,12'd1000},
    '{1'b0,1'b1,1'b1,3'd1,12'd3584,1'b1,1'b0,12'd1000},
    '{1'b0,1'b1,1'b1,3'd2,12'd4095,1'b1,1'b0,12'd1000}, // R3 saturate, run
    '{1'b1,1'b1,1'b1,3'd4,12'd4095,1'b0,1'b1,12'd0},    // R6
    '{1'b1,1'b1,1'b1,3'd4,12'd2047,1'b0,1'b1,12'd0},    // R8
    '{1'b1,1'b1,1'b1,3'd4,12'd0,   1'b0,1'b1,12'd0},    // R8 floor
    '{1'b1,1'b1,1'b1,3'd4,12'd0,   1'b0,1'b1,12'd0},    // R8 held by overcurrent
    '{1'b0,1'b1,1'b1,3'd1,12'd0,   1'b1,1'b0,12'd0},    // R8 restart
    '{1'b0,1'b1,1'b1,3'd1,12'd512, 1'b1,1'b0,12'd512},
    '{1'b1,1'b1,1'b1,3'd3,12'd1024,1'b0,1'b1,12'd0},    // R7
    '{1'b0,1'b1,1'b1,3'd3,12'd1536,1'b0,1'b1,12'd0},    // R7 deferred
    '{1'b0,1'b1,1'b1,3'd3,12'd2048,1'b0,1'b1,12'd0},
    '{1'b0,1'b1,1'b1,3'd3,12'd2560,1'b0,1'b1,12'd0},
    '{1'b0,1'b1,1'b1,3'd3,12'd3072,1'b0,1'b1,12'd0},
    '{1'b0,1'b1,1'b1,3'd3,12'd3584,1'b0,1'b1,12'd0},
    '{1'b0,1'b1,1'b1,3'd4,12'd4095,1'b0,1'b1,12'd0},    // R7 full then discharge
    '{1'b0,1'b1,1'b1,3'd4,12'd2047,1'b0,1'b1,12'd0},
    '{1'b0,1'b1,1'b1,3'd4,12'd0,   1'b0,1'b1,12'd0},
    '{1'b0,1'b1,1'b1,3'd1,12'd0,   1'b1,1'b0,12'd0},
    '{1'b0,1'b0,1'b1,3'd0,12'd0,   1'b0,1'b0,12'd0},    // R2 supply low
    '{1'b0,1'b1,1'b0,3'd0,12'd0,   1'b0,1'b0,12'd0},    // R2 reference low
    '{1'b0,1'b1,1'b1,3'd1,12'd0,   1'b1,1'b0,12'd0}
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    // R1 reset values
    chk("R1", "state", seqState, 0);
    chk("R1", "level", ssLevel, 0);
    chk("R1", "enable", outEnable, 0);
    chk("R1", "fault", faultFlag, 0);
    chk("R1", "clamp", clampedLevel, 0);
    rstN = 1'b1;
    tick();
    chk("R2", "state idle without supplies", seqState, 0);

    for (int i = 0; i < 28; i++) begin
      ovrCurrent = VECS[i].ovr;
      supplyOk   = VECS[i].sup;
      refOk      = VECS[i].rf;
      tick();
      chk($sformatf("row%0d", i), "state",  seqState,     VECS[i].st);
      chk($sformatf("row%0d", i), "level",  ssLevel,      VECS[i].lvl);
      chk($sformatf("row%0d", i), "enable", outEnable,    VECS[i].en);
      chk($sformatf("row%0d", i), "fault",  faultFlag,    VECS[i].flt);
      chk($sformatf("row%0d", i), "clamp",  clampedLevel, VECS[i].clamp);
    end

    // climb back to full ceiling
    repeat (8) tick();
    chk("R3", "state run", seqState, 2);
    chk("R3", "level full", ssLevel, 4095);
    demand = 12'd4095;
    #1;
    chk("R4", "clamp at full demand", clampedLevel, 4095);
    // R5 enable drops between edges
    ovrCurrent = 1'b1;
    #1;
    chk("R5", "enable same cycle", outEnable, 0);
    chk("R4", "clamp when disabled", clampedLevel, 0);
    chk("R6", "state before edge", seqState, 2);
    tick();
    chk("R6", "state discharge", seqState, 4);
    chk("R6", "level held full", ssLevel, 4095);
    // R2 lockout out of a fault
    refOk = 1'b0;
    tick();
    chk("R2", "state", seqState, 0);
    chk("R2", "level", ssLevel, 0);
    chk("R2", "fault", faultFlag, 0);

    // R3 full-scale step reaches run in one ramp cycle
    refOk = 1'b1;
    ovrCurrent = 1'b0;
    chargeStep = 12'd4095;
    dischargeStep = 12'd4095;
    tick();
    chk("R3", "ramp entry level", ssLevel, 0);
    tick();
    chk("R3", "run after one step", seqState, 2);
    chk("R3", "level saturated", ssLevel, 4095);

    // R8 overcurrent held after the ceiling is empty
    ovrCurrent = 1'b1;
    tick();
    chk("R6", "fault state", seqState, 4);
    tick();
    chk("R8", "empty in one step", ssLevel, 0);
    tick();
    chk("R8", "held while tripped", seqState, 4);
    tick();
    chk("R8", "still held", seqState, 4);
    chk("R8", "fault flag held", faultFlag, 1);
    ovrCurrent = 1'b0;
    tick();
    chk("R8", "restart", seqState, 1);
    chk("R8", "restart level", ssLevel, 0);

    // R1 reset in the middle of operation
    tick();
    rstN = 1'b0;
    #1;
    chk("R1", "async reset state", seqState, 0);
    chk("R1", "async reset level", ssLevel, 0);
    summary();
  end
endmodule